// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects interrupt requests from 31 groups of up to four inputs each and turns them into two signals for a processor. One is a single-cycle non-maskable pulse. The other is a 3-bit maskable priority level. Groups 0 and 1 are non-maskable. Groups 2 to 30 are maskable, and each has a programmable 3-bit level where the smaller number has the higher priority.

Each group holds four request bits and four enable bits in a control register. Inputs are numbered `group*4 + sub`. A per-group parameter decides whether a group's inputs are level-sensitive or edge-sensitive. Software reads and writes the registers through a plain register port. When the processor acknowledges an interrupt, the block records the number of the group that is currently winning in a readable accepted-group register.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset, `irq_level` is 7 and `nmi` is 0. Groups 0 and 1 have enable bits 1111 and every other group has 0000. Every level field reads 7, and the accepted group reads 0.
- R2: Register map, with read data on `rd_data` one cycle after `rd_en`:
  - address g (0..30) is group g's control register, with enable bits in bits 3:0 and request bits in bits 7:4;
  - address 32+g holds group g's level in bits 6:4;
  - address 63 holds the accepted group in bits 4:0;
  - all other bits read 0.
- R3: For a level-sensitive group, a request bit is set on every clock edge where its input is 1. Setting takes precedence over a clear in the same cycle.
- R4: A group whose bit in `EDGE_GROUPS` is 1 sets a request bit on every change of its input, rising or falling. The default marks groups 4 to 7 as edge-sensitive.
- R5: Writing a 1 to a request bit clears it, and writing a 0 leaves it unchanged. A write to a control register loads its enable bits directly.
- R6: Arbitration considers only groups 2 to 30 whose request AND enable is nonzero. Among those, the lowest level wins, and on equal levels the lowest-numbered group wins. A group at level 7 never wins.
- R7: When no maskable group qualifies, `irq_level` is 7. `irq_level` follows any change of request, enable or level state one clock later.
- R8: `nmi` pulses high for one cycle when a request bit of an enabled input in group 0 or 1 goes from 0 to 1. Non-maskable groups never affect `irq_level`.
- R9: On a clock edge with `ack` high, the accepted-group register loads the current winning group number, or 0 when no group qualifies. Without `ack` it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 8 | Registered read data |
| irq_in | input | 124 | Raw interrupt inputs, index group*4+sub |
| ack | input | 1 | Processor acknowledge of the maskable interrupt |
| nmi | output | 1 | Non-maskable interrupt pulse |
| irq_level | output | 3 | Requested maskable level, 7 when idle |

## Verification
On every cycle, the assertions check how request bits respond:
- a set sticks;
- a write of 1 clears a bit only when no set competes with it;
- an untouched bit holds;
- any change on an edge-mode input raises a set.

They also check the arbiter's choice against the stored state: the winner qualifies, no qualifying group has a strictly lower level, and no lower-numbered group ties with it. They further check that the accepted group changes only on `ack` and that `nmi` only fires while a non-maskable request is pending.

Only the bench scenarios can show the rest:
- the register map and the reset contents;
- the one-cycle delay of `irq_level`;
- falling edges setting requests;
- the write-of-zero case;
- an NMI that stays silent when its input is disabled;
- the numbers that `ack` actually captures.

// File: rtl/igc_pkg.sv
package igc_pkg;
  localparam int REG_W   = 8;  // register data width
  localparam int EN_LSB  = 0;  // enable field in control register
  localparam int REQ_LSB = 4;  // request field in control register
  localparam int LVL_LSB = 4;  // level field in level register
endpackage

// File: rtl/igc_capture.sv
// Turns raw inputs into per-bit set pulses; edge or level per group.
module igc_capture #(
  parameter int NUM_GROUPS = 31,
  parameter int SUBS       = 4,
  parameter logic [NUM_GROUPS-1:0] EDGE_GROUPS = 'h0F0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_GROUPS*SUBS-1:0] irq_in,
  output logic [NUM_GROUPS*SUBS-1:0] set_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar s = 0; s < SUBS; s++) begin : g_sub
      localparam int I = g*SUBS + s;
      if (EDGE_GROUPS[g]) begin : g_edge
        logic prev_q;
        always_ff @(posedge clk) begin
          if (rst) prev_q <= 1'b0;
          else     prev_q <= irq_in[I];
        end
        assign set_o[I] = irq_in[I] ^ prev_q;

        AST_EDGE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
          (!$past(rst) && (irq_in[I] != $past(irq_in[I]))) |-> set_o[I]); // R4
      end else begin : g_level
        assign set_o[I] = irq_in[I];
      end
    end
  end
endmodule

// File: rtl/igc_regfile.sv
// Request, enable and level storage with the register port and NMI pulse.
module igc_regfile #(
  parameter int NUM_GROUPS = 31,
  parameter int SUBS       = 4,
  parameter int NMI_GROUPS = 2,
  parameter int LVL_W      = 3,
  parameter int GRP_W      = 5,
  parameter int ADDR_W     = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [igc_pkg::REG_W-1:0]       wr_data,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [igc_pkg::REG_W-1:0]       rd_data,
  input  logic [NUM_GROUPS*SUBS-1:0]      set_i,
  input  logic [GRP_W-1:0]                acc_i,
  output logic [NUM_GROUPS-1:0][SUBS-1:0] req_o,
  output logic [NUM_GROUPS-1:0][SUBS-1:0] en_o,
  output logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_o,
  output logic                            nmi_o
);
  localparam int LVL_BASE = 1 << GRP_W;
  localparam int ACC_ADDR = 2*LVL_BASE - 1;
  localparam int REQ_LSB  = igc_pkg::REQ_LSB;
  localparam int EN_LSB   = igc_pkg::EN_LSB;
  localparam int LVL_LSB  = igc_pkg::LVL_LSB;

  logic [NUM_GROUPS-1:0][SUBS-1:0]  req_q, en_q, clr_m, set_m;
  logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_q;
  logic [NUM_GROUPS-1:0]            ctl_hit, lvl_hit;
  logic                             nmi_q, nmi_new, nmi_pend;
  logic [GRP_W-1:0]                 rd_idx;

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      ctl_hit[g] = wr_en && (wr_addr == ADDR_W'(g));
      lvl_hit[g] = wr_en && (wr_addr == ADDR_W'(LVL_BASE + g));
      clr_m[g]   = ctl_hit[g] ? wr_data[REQ_LSB +: SUBS] : '0;
      set_m[g]   = set_i[g*SUBS +: SUBS];
    end
  end

  always_comb begin
    nmi_new  = 1'b0;
    nmi_pend = 1'b0;
    for (int g = 0; g < NMI_GROUPS; g++) begin
      nmi_new  = nmi_new  | (|(set_m[g] & ~req_q[g] & en_q[g]));
      nmi_pend = nmi_pend | (|req_q[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        en_q[g]  <= (g < NMI_GROUPS) ? '1 : '0;
        req_q[g] <= '0;
        lvl_q[g] <= '1;
      end
      nmi_q <= 1'b0;
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        req_q[g] <= (req_q[g] & ~clr_m[g]) | set_m[g];
        if (ctl_hit[g]) en_q[g]  <= wr_data[EN_LSB +: SUBS];
        if (lvl_hit[g]) lvl_q[g] <= wr_data[LVL_LSB +: LVL_W];
      end
      nmi_q <= nmi_new;
    end
  end

  assign rd_idx = rd_addr[GRP_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      if (rd_addr < ADDR_W'(NUM_GROUPS)) begin
        rd_data[REQ_LSB +: SUBS] <= req_q[rd_idx];
        rd_data[EN_LSB  +: SUBS] <= en_q[rd_idx];
      end else if (rd_addr >= ADDR_W'(LVL_BASE) &&
                   rd_addr <  ADDR_W'(LVL_BASE + NUM_GROUPS)) begin
        rd_data[LVL_LSB +: LVL_W] <= lvl_q[rd_idx];
      end else if (rd_addr == ADDR_W'(ACC_ADDR)) begin
        rd_data[GRP_W-1:0] <= acc_i;
      end
    end
  end

  assign req_o = req_q;
  assign en_o  = en_q;
  assign lvl_o = lvl_q;
  assign nmi_o = nmi_q;

  AST_NMI_SOURCE: assert property (@(posedge clk) disable iff (rst)
    nmi_q |-> nmi_pend); // R8

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (en_q[g] == ((g < NMI_GROUPS) ? {SUBS{1'b1}} : {SUBS{1'b0}}))
                     && (lvl_q[g] == {LVL_W{1'b1}})); // R1
    for (genvar s = 0; s < SUBS; s++) begin : g_bit
      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i[g*SUBS+s] |=> req_q[g][s]); // R3
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(g) && wr_data[REQ_LSB+s] && !set_i[g*SUBS+s])
        |=> !req_q[g][s]); // R5
      AST_REQ_KEEP: assert property (@(posedge clk) disable iff (rst)
        (req_q[g][s] && !(wr_en && wr_addr == ADDR_W'(g) && wr_data[REQ_LSB+s]))
        |=> req_q[g][s]); // R5
    end
  end
endmodule

// File: rtl/igc_arbiter.sv
// Scans maskable groups; strictly lower level replaces the current choice.
module igc_arbiter #(
  parameter int NUM_GROUPS = 31,
  parameter int SUBS       = 4,
  parameter int NMI_GROUPS = 2,
  parameter int LVL_W      = 3,
  parameter int GRP_W      = 5
) (
  input  logic [NUM_GROUPS-1:0][SUBS-1:0]  req_i,
  input  logic [NUM_GROUPS-1:0][SUBS-1:0]  en_i,
  input  logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_i,
  output logic [GRP_W-1:0]                 win_grp,
  output logic [LVL_W-1:0]                 win_lvl
);
  always_comb begin
    win_lvl = '1;
    win_grp = '0;
    for (int g = NMI_GROUPS; g < NUM_GROUPS; g++) begin
      if ((|(req_i[g] & en_i[g])) && (lvl_i[g] < win_lvl)) begin
        win_lvl = lvl_i[g];
        win_grp = GRP_W'(g);
      end
    end
  end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl #(
  parameter int NUM_GROUPS = 31,
  parameter int SUBS       = 4,
  parameter int NMI_GROUPS = 2,
  parameter int LVL_W      = 3,
  parameter logic [NUM_GROUPS-1:0] EDGE_GROUPS = 'h0F0
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [$clog2(NUM_GROUPS):0]         wr_addr,
  input  logic [igc_pkg::REG_W-1:0]           wr_data,
  input  logic                                rd_en,
  input  logic [$clog2(NUM_GROUPS):0]         rd_addr,
  output logic [igc_pkg::REG_W-1:0]           rd_data,
  input  logic [NUM_GROUPS*SUBS-1:0]          irq_in,
  input  logic                                ack,
  output logic                                nmi,
  output logic [LVL_W-1:0]                    irq_level
);
  localparam int GRP_W  = $clog2(NUM_GROUPS);
  localparam int ADDR_W = GRP_W + 1;

  logic [NUM_GROUPS*SUBS-1:0]       set_w;
  logic [NUM_GROUPS-1:0][SUBS-1:0]  req_w, en_w;
  logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_w;
  logic [GRP_W-1:0]                 win_grp, acc_q;
  logic [LVL_W-1:0]                 win_lvl;

  igc_capture #(.NUM_GROUPS(NUM_GROUPS), .SUBS(SUBS), .EDGE_GROUPS(EDGE_GROUPS)) u_cap (
    .clk(clk), .rst(rst), .irq_in(irq_in), .set_o(set_w)
  );

  igc_regfile #(.NUM_GROUPS(NUM_GROUPS), .SUBS(SUBS), .NMI_GROUPS(NMI_GROUPS),
                .LVL_W(LVL_W), .GRP_W(GRP_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .set_i(set_w), .acc_i(acc_q),
    .req_o(req_w), .en_o(en_w), .lvl_o(lvl_w), .nmi_o(nmi)
  );

  igc_arbiter #(.NUM_GROUPS(NUM_GROUPS), .SUBS(SUBS), .NMI_GROUPS(NMI_GROUPS),
                .LVL_W(LVL_W), .GRP_W(GRP_W)) u_arb (
    .req_i(req_w), .en_i(en_w), .lvl_i(lvl_w),
    .win_grp(win_grp), .win_lvl(win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= '1;
      acc_q     <= '0;
    end else begin
      irq_level <= win_lvl;
      if (ack) acc_q <= win_grp;
    end
  end

  AST_WIN_VALID: assert property (@(posedge clk) disable iff (rst)
    (win_lvl != {LVL_W{1'b1}}) |-> (win_grp >= GRP_W'(NMI_GROUPS))
      && (|(req_w[win_grp] & en_w[win_grp])) && (lvl_w[win_grp] == win_lvl)); // R6
  AST_IDLE_GROUP: assert property (@(posedge clk) disable iff (rst)
    (win_lvl == {LVL_W{1'b1}}) |-> (win_grp == '0)); // R9
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ack |=> $stable(acc_q)); // R9

  for (genvar g = NMI_GROUPS; g < NUM_GROUPS; g++) begin : g_arb_chk
    AST_WIN_MIN: assert property (@(posedge clk) disable iff (rst)
      ((|(req_w[g] & en_w[g])) && lvl_w[g] != {LVL_W{1'b1}}) |-> (win_lvl <= lvl_w[g])); // R6
    AST_WIN_TIE: assert property (@(posedge clk) disable iff (rst)
      ((|(req_w[g] & en_w[g])) && lvl_w[g] == win_lvl && win_lvl != {LVL_W{1'b1}})
      |-> (win_grp <= GRP_W'(g))); // R6
  end
endmodule

// File: tb/irq_group_ctrl_bench.sv
`timescale 1ns/1ps
module irq_group_ctrl_bench;
  localparam int NG = 31;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [NG*NS-1:0] irq_in = '0;
  logic nmi;
  logic [2:0] irq_level;

  always #2 clk = ~clk;

  irq_group_ctrl u_irq_group_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_in(irq_in),
    .ack(ack), .nmi(nmi), .irq_level(irq_level)
  );

  typedef struct { string tag; int sel; int exp; } item_t;
  item_t sb_q[$];
  event  smp_ev;
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;

  // monitor: pops the expected item and compares against the port it names
  initial forever begin
    item_t it;
    int act;
    @(smp_ev);
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.sel)
        0: act = int'(irq_level);
        1: act = int'(nmi);
        default: act = int'(rd_data);
      endcase
      n_cmp++;
      if (act != it.exp) begin
        n_bad++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_now(string tag, int sel, int exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
    -> smp_ev;
    #1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 8'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(int a, int exp, string tag);
    rd_en = 1'b1; rd_addr = 6'(a);
    tick();
    rd_en = 1'b0;
    expect_now(tag, 2, exp);
  endtask

  task automatic lvl_chk(int exp, string tag);
    tick();
    expect_now(tag, 0, exp);
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_now("R1 level after reset", 0, 7);
    expect_now("R1 nmi after reset", 1, 0);
    rd_chk(0,  8'h0F, "R1 R2 ctrl g0 enables");
    rd_chk(2,  8'h00, "R1 R2 ctrl g2 enables");
    rd_chk(37, 8'h70, "R1 R2 level g5");
    rd_chk(63, 0,     "R1 R2 accepted group");

    // R6 R7 single level group
    wr(3, 8'h01); wr(35, 8'h20);
    irq_in[12] = 1'b1; tick();
    lvl_chk(2, "R6 R7 g3 level 2");
    rd_chk(3, 8'h11, "R3 ctrl g3 request");

    // R6 disabled request ignored, level 7 group never wins
    irq_in[8] = 1'b1; tick();
    lvl_chk(2, "R6 disabled g2 ignored");
    rd_chk(2, 8'h10, "R3 g2 request without enable");
    wr(2, 8'h01);
    lvl_chk(2, "R6 level-7 g2 never wins");
    do_ack();
    rd_chk(63, 3, "R9 ack captures g3");

    // R6 tie on equal level -> lower group
    wr(9, 8'h04); wr(41, 8'h20);
    irq_in[38] = 1'b1; tick();
    lvl_chk(2, "R6 tie level");
    do_ack();
    rd_chk(63, 3, "R6 tie lower group wins");

    // R6 strictly lower level wins
    wr(20, 8'h08); wr(52, 8'h10);
    irq_in[83] = 1'b1; tick();
    lvl_chk(1, "R6 lower level wins");
    do_ack();
    rd_chk(63, 20, "R9 ack captures g20");

    // R3 set beats clear while input held
    wr(20, 8'h88);
    rd_chk(20, 8'h88, "R3 set wins over clear");
    // R5 write zero keeps, write one clears
    irq_in[83] = 1'b0; tick();
    wr(20, 8'h08);
    rd_chk(20, 8'h88, "R5 write 0 keeps request");
    wr(20, 8'h88);
    rd_chk(20, 8'h08, "R5 write 1 clears request");
    lvl_chk(2, "R7 level follows clear");
    do_ack();
    rd_chk(63, 3, "R9 g3 again");

    irq_in[12] = 1'b0; tick();
    wr(3, 8'h11);
    lvl_chk(2, "R6 g9 after g3 cleared");
    do_ack();
    rd_chk(63, 9, "R9 ack captures g9");

    irq_in[38] = 1'b0; tick();
    wr(9, 8'h44);
    lvl_chk(7, "R7 idle level 7");
    do_ack();
    rd_chk(63, 0, "R9 ack with no winner");

    // R4 edge group 5: both edges set
    wr(5, 8'h02); wr(37, 8'h30);
    irq_in[21] = 1'b1; tick();
    lvl_chk(3, "R4 rising edge request");
    rd_chk(5, 8'h22, "R4 ctrl after rise");
    wr(5, 8'h22);
    rd_chk(5, 8'h02, "R4 held input no new set");
    lvl_chk(7, "R4 R7 idle after clear");
    irq_in[21] = 1'b0; tick();
    rd_chk(5, 8'h22, "R4 falling edge request");
    lvl_chk(3, "R4 level after fall");
    wr(5, 8'h22);
    rd_chk(5, 8'h02, "R5 edge request cleared");

    // R8 NMI pulse
    irq_in[0] = 1'b1; tick();
    expect_now("R8 nmi pulse high", 1, 1);
    tick();
    expect_now("R8 nmi pulse one cycle", 1, 0);
    lvl_chk(7, "R8 nmi group not in level");
    wr(1, 8'h00);
    irq_in[5] = 1'b1; tick();
    expect_now("R8 disabled nmi input silent", 1, 0);
    rd_chk(1, 8'h20, "R8 disabled nmi request stored");
    irq_in[0] = 1'b0; tick();
    wr(0, 8'h1F);
    irq_in[0] = 1'b1; tick();
    expect_now("R8 nmi refires after clear", 1, 1);
    tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule